// File: doc/BRIEF.md
# IOMMU Control Register Front End

This block is the register-write front end of an address-translation unit's control space. A single write port carries an address and a 32-bit data word. The block decodes the address and updates one of these: the control word and its acknowledge mirror, an interrupt-enable bit, the error-acknowledge word, or one of the command/event queue base registers. The identification words are read-only, and writes to them are dropped. A separate combinational read port returns the stored value of any mapped register.

Global errors are raised by one-cycle pulses on `err_raise`. An error is outstanding while its bit in the error word differs from the same bit in the error-acknowledge word. Software clears an error by writing the acknowledge word so that the bit matches again. Every write to the acknowledge word also produces a one-cycle restart pulse, which tells the command queue consumer to resume fetching.

Top module: `iommu_ctl_front`

## Requirements
- R1: After reset, every stored register reads zero, and `gerr_irq` and `cmdq_restart` are low.
- R2: A write to the control word at byte offset 0x020 stores the data. The acknowledge word at 0x024 holds the same value from the next cycle on, so both read back equal.
- R3: A write to the acknowledge word at 0x024 has no effect.
- R4: A write to queue base n, at byte offset 0x090 + 0x10*n (n < NQ), stores the data with bits 5:0 and bit RA_BIT (default 30) forced to zero.
- R5: Writes to the identification words at 0x000 to 0x014 and to the window 0xFDC to 0xFFC are dropped. Reads of those words return ID_SEED XOR the byte offset.
- R6: A pulse on `err_raise` bit i flips bit i of the error word at 0x060, but only if that error is not already outstanding. A pulse on an outstanding bit changes nothing.
- R7: A write to the acknowledge word at 0x064 takes the written value only in bits whose error is outstanding. All other bits keep their previous value.
- R8: Every write to 0x064 drives `cmdq_restart` high for exactly the one cycle after the write. No other write raises it.
- R9: `gerr_irq` is high exactly while the interrupt enable is set and at least one error is outstanding.
- R10: Writes to unmapped or misaligned addresses are ignored, and reads of them return zero.
- R11: The interrupt-enable word at 0x050 stores only bit 0. Its other bits always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | AW (12) | Write byte address |
| wr_data | input | DW (32) | Write data |
| rd_addr | input | AW (12) | Read byte address |
| rd_data | output | DW (32) | Combinational read data |
| err_raise | input | EW (8) | One-cycle error raise pulses |
| ctrl_word | output | DW (32) | Current control word |
| q_base | output | NQ*DW (64) | Queue base registers, queue n at bits [n*DW +: DW] |
| gerr_irq | output | 1 | Global error interrupt |
| cmdq_restart | output | 1 | Command queue restart pulse |

## Verification
The bench targets several ways the block can go wrong:
- Acknowledge writes that also carry bits for errors that are not outstanding: a design that copied the whole word would create false errors or hide real ones.
- Raising an error that is already outstanding: a plain toggle would silently clear it.
- Writes to the identification space, the high window, the acknowledge mirror and unmapped gaps, each followed by a full readback: a loose decoder would corrupt a neighbouring register.
- Timing of the restart pulse: a design that held it, or fired it on other writes, would fail the one-cycle check.

// File: rtl/iommu_ctl_pkg.sv
// Package: shared register selector type and byte offsets of the control space.
package iommu_ctl_pkg;
    typedef enum logic [3:0] {
        RS_NONE,
        RS_ID,
        RS_IDWIN,
        RS_CTRL,
        RS_CTRLACK,
        RS_IRQEN,
        RS_ERR,
        RS_ERRACK,
        RS_QBASE
    } reg_sel_e;

    localparam int ID_WORDS   = 6;
    localparam int CTRL_OFF   = 'h020;
    localparam int CACK_OFF   = 'h024;
    localparam int IRQEN_OFF  = 'h050;
    localparam int ERR_OFF    = 'h060;
    localparam int EACK_OFF   = 'h064;
    localparam int QB_OFF     = 'h090;
    localparam int QB_STRIDE  = 'h010;
    localparam int WIN_LO     = 'hFDC;
    localparam int WIN_HI     = 'hFFC;
endpackage

// File: rtl/iommu_ctl_decode.sv
// Address decoder: maps a byte address to a register selector and queue index.
// Assumes AW >= 12; misaligned addresses decode to RS_NONE.
module iommu_ctl_decode
    import iommu_ctl_pkg::*;
#(
    parameter int AW  = 12,
    parameter int NQ  = 2,
    localparam int QIW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic [AW-1:0]  addr,
    output reg_sel_e       sel,
    output logic [QIW-1:0] qidx
);
    // Purpose: compare the aligned address against every mapped region.
    always_comb begin
        sel  = RS_NONE;
        qidx = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr < AW'(ID_WORDS * 4))
                sel = RS_ID;
            else if (addr >= AW'(WIN_LO) && addr <= AW'(WIN_HI))
                sel = RS_IDWIN;
            else if (addr == AW'(CTRL_OFF))
                sel = RS_CTRL;
            else if (addr == AW'(CACK_OFF))
                sel = RS_CTRLACK;
            else if (addr == AW'(IRQEN_OFF))
                sel = RS_IRQEN;
            else if (addr == AW'(ERR_OFF))
                sel = RS_ERR;
            else if (addr == AW'(EACK_OFF))
                sel = RS_ERRACK;
            else begin
                for (int q = 0; q < NQ; q++) begin
                    if (addr == AW'(QB_OFF + q * QB_STRIDE)) begin
                        sel  = RS_QBASE;
                        qidx = QIW'(q);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/iommu_ctl_errtrack.sv
// Error tracker: error word and its acknowledge word; an error is outstanding
// while the two differ. Raises flip only idle bits; acknowledges touch only
// outstanding bits. Assumes raise pulses last one cycle.
module iommu_ctl_errtrack #(
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] raise,
    input  logic          ack_wr,
    input  logic [EW-1:0] ack_data,
    output logic [EW-1:0] err_q,
    output logic [EW-1:0] ack_q,
    output logic [EW-1:0] pend
);
    assign pend = err_q ^ ack_q;

    // Purpose: update error and acknowledge words under the toggle-match rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
            ack_q <= '0;
        end else begin
            err_q <= err_q ^ (raise & ~pend);
            if (ack_wr)
                ack_q <= (ack_q & ~pend) | (ack_data & pend);
        end
    end

    // R6: an outstanding error bit never changes on the error side
    a_r6_raise_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_q ^ $past(err_q)) & $past(pend)) == '0);
    // R7: acknowledge bits move only where an error was outstanding
    a_r7_ack_pending_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_q ^ $past(ack_q)) & ~$past(pend)) == '0);
    // R7: without an acknowledge write the acknowledge word holds
    a_r7_ack_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_wr |=> $stable(ack_q));
endmodule

// File: rtl/iommu_ctl_qbase.sv
// Queue base register: stores a write with the low alignment bits and the
// read-allocate hint bit cleared. Assumes RA_BIT lies above bit 5.
module iommu_ctl_qbase #(
    parameter int DW     = 32,
    parameter int RA_BIT = 30,
    localparam logic [DW-1:0] KEEP = ~((DW'(1) << RA_BIT) | DW'(6'h3f))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] base
);
    // Purpose: capture masked base address on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base <= '0;
        else if (wr)
            base <= wdata & KEEP;
    end

    // R4: cleared bits never hold a one
    a_r4_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (base & ~KEEP) == '0);
endmodule

// File: rtl/iommu_ctl_front.sv
// Control register front end: decodes writes into control, mirror,
// interrupt-enable, error-acknowledge and queue-base registers, drops writes
// to identification space, and pulses a command queue restart after every
// error-acknowledge write. Assumes one write per cycle.
module iommu_ctl_front
    import iommu_ctl_pkg::*;
#(
    parameter int          AW      = 12,
    parameter int          DW      = 32,
    parameter int          EW      = 8,
    parameter int          NQ      = 2,
    parameter int          RA_BIT  = 30,
    parameter logic [31:0] ID_SEED = 32'h5A3C_0000,
    localparam int         QIW     = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic [EW-1:0]    err_raise,
    output logic [DW-1:0]    ctrl_word,
    output logic [NQ*DW-1:0] q_base,
    output logic             gerr_irq,
    output logic             cmdq_restart
);
    reg_sel_e       wr_sel, rd_sel;
    logic [QIW-1:0] wr_qidx, rd_qidx;
    logic [DW-1:0]  ctrl_q, cack_q;
    logic           irq_en_q;
    logic [EW-1:0]  err_q, eack_q, pend;
    logic           restart_q;
    logic [DW-1:0]  qb [NQ];

    iommu_ctl_decode #(.AW(AW), .NQ(NQ)) u_wdec (
        .addr(wr_addr), .sel(wr_sel), .qidx(wr_qidx));
    iommu_ctl_decode #(.AW(AW), .NQ(NQ)) u_rdec (
        .addr(rd_addr), .sel(rd_sel), .qidx(rd_qidx));

    iommu_ctl_errtrack #(.EW(EW)) u_err (
        .clk(clk), .rst_n(rst_n), .raise(err_raise),
        .ack_wr(wr_en && wr_sel == RS_ERRACK), .ack_data(wr_data[EW-1:0]),
        .err_q(err_q), .ack_q(eack_q), .pend(pend));

    for (genvar q = 0; q < NQ; q++) begin : g_q
        iommu_ctl_qbase #(.DW(DW), .RA_BIT(RA_BIT)) u_qb (
            .clk(clk), .rst_n(rst_n),
            .wr(wr_en && wr_sel == RS_QBASE && wr_qidx == QIW'(q)),
            .wdata(wr_data), .base(qb[q]));
        assign q_base[q*DW +: DW] = qb[q];
    end

    // Purpose: control word with its same-write acknowledge mirror.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cack_q <= '0;
        end else if (wr_en && wr_sel == RS_CTRL) begin
            ctrl_q <= wr_data;
            cack_q <= wr_data;
        end
    end

    // Purpose: single-bit interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en_q <= 1'b0;
        else if (wr_en && wr_sel == RS_IRQEN)
            irq_en_q <= wr_data[0];
    end

    // Purpose: one-cycle restart pulse after each error-acknowledge write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            restart_q <= 1'b0;
        else
            restart_q <= wr_en && wr_sel == RS_ERRACK;
    end

    assign ctrl_word    = ctrl_q;
    assign cmdq_restart = restart_q;
    assign gerr_irq     = irq_en_q && (pend != '0);

    // Purpose: combinational readback of the addressed register.
    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            RS_ID, RS_IDWIN: rd_data = DW'(ID_SEED) ^ DW'(rd_addr);
            RS_CTRL:         rd_data = ctrl_q;
            RS_CTRLACK:      rd_data = cack_q;
            RS_IRQEN:        rd_data = DW'(irq_en_q);
            RS_ERR:          rd_data = DW'(err_q);
            RS_ERRACK:       rd_data = DW'(eack_q);
            RS_QBASE: begin
                for (int q = 0; q < NQ; q++)
                    if (rd_qidx == QIW'(q)) rd_data = qb[q];
            end
            default:         rd_data = '0;
        endcase
    end

    // R2: a control write lands in both the word and its mirror
    a_r2_ctrl_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == RS_CTRL) |=>
            (ctrl_q == $past(wr_data)) && (cack_q == $past(wr_data)));
    // R8: acknowledge write is followed by the restart pulse
    a_r8_restart_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == RS_ERRACK) |=> cmdq_restart);
    // R8: no restart without an acknowledge write
    a_r8_no_spurious_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == RS_ERRACK) |=> !cmdq_restart);
    // R5: identification writes leave stored state alone
    a_r5_id_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == RS_ID || wr_sel == RS_IDWIN)) |=>
            $stable(ctrl_q) && $stable(irq_en_q) && $stable(eack_q));
    // R9: interrupt stays low while disabled
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_q |-> !gerr_irq);
endmodule

// File: tb/test_iommu_ctl_front.sv
// Bench: directed corner cases, then seeded random writes and raises, each
// followed by a full readback compared with a bench-side model.
module test_iommu_ctl_front;
    localparam logic [31:0] SEED_ID = 32'h5A3C_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  err_raise = '0;
    logic [31:0] ctrl_word;
    logic [63:0] q_base;
    logic        gerr_irq, cmdq_restart;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_ctrl, m_cack, m_qb0, m_qb1;
    logic        m_irqen;
    logic [7:0]  m_err, m_eack;

    logic [11:0] addrs [16] = '{12'h000, 12'h014, 12'h020, 12'h024, 12'h050,
        12'h060, 12'h064, 12'h090, 12'h0A0, 12'h0B0, 12'hFDC, 12'hFFC,
        12'h100, 12'h02C, 12'hFE0, 12'h018};

    iommu_ctl_front i_iommu_ctl_front (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .err_raise(err_raise), .ctrl_word(ctrl_word), .q_base(q_base),
        .gerr_irq(gerr_irq), .cmdq_restart(cmdq_restart));

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a < 12'h018 || a >= 12'hFDC) return SEED_ID ^ {20'h0, a};
        case (a)
            12'h020: return m_ctrl;
            12'h024: return m_cack;
            12'h050: return {31'h0, m_irqen};
            12'h060: return {24'h0, m_err};
            12'h064: return {24'h0, m_eack};
            12'h090: return m_qb0;
            12'h0A0: return m_qb1;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return m_irqen && ((m_err ^ m_eack) != 8'h0);
    endfunction

    task automatic model_reset();
        m_ctrl = '0; m_cack = '0; m_qb0 = '0; m_qb1 = '0;
        m_irqen = 1'b0; m_err = '0; m_eack = '0;
    endtask

    task automatic readback_all(string tag);
        foreach (addrs[i]) begin
            rd_addr = addrs[i];
            #1;
            chk(tag, rd_data, exp_rd(addrs[i]), $sformatf("read %h", addrs[i]));
        end
        chk(tag, ctrl_word, m_ctrl, "ctrl_word port");
        chk(tag, q_base[31:0], m_qb0, "q_base0 port");
        chk(tag, q_base[63:32], m_qb1, "q_base1 port");
        chk("R9", {31'h0, gerr_irq}, {31'h0, exp_irq()}, "gerr_irq");
    endtask

    // One operation: optional write plus raise pulses, then full check.
    task automatic do_op(logic we, logic [11:0] a, logic [31:0] d, logic [7:0] rz, string tag);
        logic [7:0] pend;
        logic       ack_hit;
        @(negedge clk);
        chk("R8", {31'h0, cmdq_restart}, 32'h0, "restart idle before op");
        wr_en = we; wr_addr = a; wr_data = d; err_raise = rz;
        @(negedge clk);
        wr_en = 1'b0; err_raise = '0;
        pend = m_err ^ m_eack;
        ack_hit = we && a == 12'h064;
        m_err = m_err ^ (rz & ~pend);
        if (ack_hit) m_eack = (m_eack & ~pend) | (d[7:0] & pend);
        if (we) begin
            case (a)
                12'h020: begin m_ctrl = d; m_cack = d; end
                12'h050: m_irqen = d[0];
                12'h090: m_qb0 = d & 32'hBFFF_FFC0;
                12'h0A0: m_qb1 = d & 32'hBFFF_FFC0;
                default: ;
            endcase
        end
        #1;
        chk("R8", {31'h0, cmdq_restart}, {31'h0, ack_hit}, "restart after op");
        readback_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", {31'h0, cmdq_restart}, 32'h0, "restart after reset");
        readback_all("R1");

        do_op(1'b1, 12'h020, 32'hDEAD_BEEF, 8'h00, "R2");
        chk("R2", m_cack, 32'hDEAD_BEEF, "mirror model");
        do_op(1'b1, 12'h024, 32'h1234_5678, 8'h00, "R3");
        do_op(1'b1, 12'h090, 32'hFFFF_FFFF, 8'h00, "R4");
        chk("R4", q_base[31:0], 32'hBFFF_FFC0, "masked base");
        do_op(1'b1, 12'h0A0, 32'h4000_007F, 8'h00, "R4");
        chk("R4", q_base[63:32], 32'h0000_0040, "masked base 1");
        do_op(1'b1, 12'h000, 32'hFFFF_FFFF, 8'h00, "R5");
        do_op(1'b1, 12'hFFC, 32'hFFFF_FFFF, 8'h00, "R5");
        do_op(1'b1, 12'h100, 32'hFFFF_FFFF, 8'h00, "R10");
        do_op(1'b1, 12'h022, 32'hFFFF_FFFF, 8'h00, "R10");
        do_op(1'b0, 12'h000, 32'h0, 8'h01, "R6");
        chk("R6", {31'h0, gerr_irq}, 32'h0, "irq off while disabled");
        do_op(1'b1, 12'h050, 32'hFFFF_FFFF, 8'h00, "R11");
        chk("R9", {31'h0, gerr_irq}, 32'h1, "irq on when enabled and pending");
        do_op(1'b0, 12'h000, 32'h0, 8'h01, "R6");
        chk("R6", {24'h0, m_err}, 32'h1, "raise on outstanding bit ignored");
        do_op(1'b1, 12'h064, 32'h0000_00FF, 8'h00, "R7");
        chk("R7", {24'h0, m_eack}, 32'h1, "only outstanding bit acknowledged");
        do_op(1'b1, 12'h064, 32'h0000_0000, 8'h00, "R8");
        do_op(1'b0, 12'h000, 32'h0, 8'h06, "R6");
        do_op(1'b1, 12'h064, 32'h0000_0002, 8'h06, "R7");

        for (int k = 0; k < 400; k++) begin
            logic [11:0] a;
            logic [7:0]  rz;
            a  = addrs[$urandom_range(15)];
            rz = ($urandom_range(3) == 0) ? 8'($urandom) : 8'h00;
            do_op($urandom_range(3) != 0, a, $urandom, rz, "R7");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule